// File: doc/BRIEF.md
# Processor Clock and Reset Generator

This block derives a processor clock and a slower peripheral clock from a fast reference source. It also produces a clean reset level for the processor. A strap input chooses between two source inputs: an on-board oscillator signal and an externally supplied frequency. The chosen source is passed straight through on a monitor output. Each rising edge of the source advances a three-state phase counter. The processor clock is high in one of the three states, which gives a one-third duty cycle. A toggle flop, driven by the wrap of that counter, gives a peripheral clock at half the processor clock rate with equal high and low times. For example, a 15 MHz source gives a 5 MHz processor clock and a 2.5 MHz peripheral clock.

All logic runs on a single fast system clock. The two source inputs are treated as data levels. The selected source is synchronized and edge-detected, so the generated clocks are registered outputs with no glitches. An active-low reset request can arrive at any time; it is synchronized into the system clock domain. The processor reset output samples that request only at the instant the generated processor clock falls, so a processor that samples on the rising edge always sees a settled level. A synchronous active-high power-on reset puts the counter and both clocks into a known phase.

Each level of the selected source must last at least two system clock cycles.

Top module: `cpu_clkrst_gen`

## Requirements
- R1: With `fc_sel_i` = 0 the oscillator input drives the counter, and with `fc_sel_i` = 1 the external input drives it; `osc_o` always equals the level of the selected input.
- R2: `cpu_clk_o` has a period of exactly three periods of the selected source, and it is high for exactly one source period of each cycle.
- R3: `per_clk_o` has a period of exactly six periods of the selected source, and it is high for exactly three of them.
- R4: While the selected source stops toggling, `cpu_clk_o` and `per_clk_o` hold their levels.
- R5: After `req_n_i` goes low, `rst_o` rises before `cpu_clk_o` completes four rising edges.
- R6: `rst_o` changes only in the system clock cycle in which `cpu_clk_o` falls from 1 to 0.
- R7: If `req_n_i` is released just after a falling edge of `cpu_clk_o`, then `rst_o` drops at the next falling edge of `cpu_clk_o`.
- R8: While `rst_i` is high, `cpu_clk_o` = 0, `per_clk_o` = 0 and `rst_o` = 1. After `rst_i` is released, the first rising edge of `cpu_clk_o` coincides with a rising edge of `per_clk_o`.
- R9: `per_clk_o` changes level only in the cycle in which `cpu_clk_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock that samples the sources |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| fc_sel_i | input | 1 | Source select: 0 oscillator input, 1 external input |
| osc_i | input | 1 | Oscillator source level |
| ext_i | input | 1 | External frequency source level |
| req_n_i | input | 1 | Asynchronous active-low reset request |
| osc_o | output | 1 | Selected source, passed through |
| cpu_clk_o | output | 1 | Processor clock, 1/3 of source, 33% high |
| per_clk_o | output | 1 | Peripheral clock, 1/6 of source, 50% high |
| rst_o | output | 1 | Processor reset, updated on the falling edge of cpu_clk_o |

## Verification
Two kinds of internal fault show up at the ports within one processor clock period:
- A counter that skips a state or decodes the wrong one shows up as a wrong high or low time.
- A peripheral toggle that fires off the wrap shows up as a peripheral clock edge that does not line up with a processor clock rise.

A fault in the reset path shows up at the next falling edge of the processor clock. Either the reset level moves on some other cycle, or it misses the falling edge that should have carried the new request level. The power-on phase shows up on the first generated rising edge after release.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

    // Phase counter states; the processor clock is high only in PH_HIGH.
    typedef enum logic [1:0] {
        PH_HIGH  = 2'd0,
        PH_LOW_A = 2'd1,
        PH_LOW_B = 2'd2
    } phase_e;

    // Registered divider state carried as one word.
    typedef struct packed {
        phase_e phase;
        logic   cpu_clk;
        logic   per_clk;
    } div_state_t;

    // Power-on state: the last low phase, so the first tick opens a high phase.
    localparam div_state_t DIV_RESET = '{phase: PH_LOW_B, cpu_clk: 1'b0, per_clk: 1'b0};

    // Successor phase of the divide-by-3 counter.
    function automatic phase_e phase_next(input phase_e p);
        phase_e n;
        case (p)
            PH_HIGH:  n = PH_LOW_A;
            PH_LOW_A: n = PH_LOW_B;
            default:  n = PH_HIGH;
        endcase
        return n;
    endfunction

    // True when the given phase drives the processor clock high.
    function automatic logic phase_drives_high(input phase_e p);
        return p == PH_HIGH;
    endfunction

    // Full divider update for one source tick.
    function automatic div_state_t div_step(input div_state_t s);
        div_state_t n;
        n.phase   = phase_next(s.phase);
        n.cpu_clk = phase_drives_high(n.phase);
        // The peripheral clock toggles whenever the counter wraps to PH_HIGH.
        n.per_clk = (n.phase == PH_HIGH) ? ~s.per_clk : s.per_clk;
        return n;
    endfunction

endpackage

// File: rtl/crg_src_select.sv
module crg_src_select #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fc_sel_i,
    input  logic osc_i,
    input  logic ext_i,
    output logic src_o,
    output logic tick_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic             sel_raw;
    logic [LAST:0]    sync_q;
    logic             prev_q;

    // Source multiplexer; also the pass-through output.
    assign sel_raw = fc_sel_i ? ext_i : osc_i;
    assign src_o   = sel_raw;

    // Synchronizer chain; stage 0 takes the raw level.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= sel_raw;
        end
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    sync_q[g] <= 1'b0;
                end else begin
                    sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Edge detector on the settled level.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    assign tick_o = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/crg_divider.sv
module crg_divider
    import clkrst_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    output logic cpu_clk_o,
    output logic per_clk_o,
    output logic fall_o
);

    div_state_t state_q;
    div_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d = div_step(state_q);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= DIV_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_clk_o = state_q.cpu_clk;
    assign per_clk_o = state_q.per_clk;
    // The processor clock falls on the edge that leaves the high phase.
    assign fall_o    = tick_i & phase_drives_high(state_q.phase);

endmodule

// File: rtl/crg_reset_sync.sv
module crg_reset_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_n_i,
    input  logic fall_i,
    output logic rst_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] req_q;
    logic          rst_q;

    // Active-high copy of the request, synchronized.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q[0] <= 1'b1;
        end else begin
            req_q[0] <= ~req_n_i;
        end
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_req
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    req_q[g] <= 1'b1;
                end else begin
                    req_q[g] <= req_q[g-1];
                end
            end
        end
    endgenerate

    // Output flop loads only when the generated clock falls.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rst_q <= 1'b1;
        end else if (fall_i) begin
            rst_q <= req_q[LAST];
        end
    end

    assign rst_o = rst_q;

endmodule

// File: rtl/cpu_clkrst_gen.sv
module cpu_clkrst_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fc_sel_i,
    input  logic osc_i,
    input  logic ext_i,
    input  logic req_n_i,
    output logic osc_o,
    output logic cpu_clk_o,
    output logic per_clk_o,
    output logic rst_o
);

    logic src_tick;
    logic clk_fall;

    crg_src_select #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_src (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .fc_sel_i(fc_sel_i),
        .osc_i   (osc_i),
        .ext_i   (ext_i),
        .src_o   (osc_o),
        .tick_o  (src_tick)
    );

    crg_divider u_div (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (src_tick),
        .cpu_clk_o(cpu_clk_o),
        .per_clk_o(per_clk_o),
        .fall_o   (clk_fall)
    );

    crg_reset_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rst (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_n_i(req_n_i),
        .fall_i (clk_fall),
        .rst_o  (rst_o)
    );

endmodule

// File: rtl/cpu_clkrst_gen_chk.sv
module cpu_clkrst_gen_chk (
    input logic clk_i,
    input logic rst_i,
    input logic src_tick,
    input logic req_n,
    input logic cpu_clk,
    input logic per_clk,
    input logic rst_out
);

    // Processor clock rises seen while a request waits for rst_out.
    logic [3:0] pend_rises;
    logic       cpu_prev;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_rises <= '0;
            cpu_prev   <= 1'b0;
        end else begin
            cpu_prev <= cpu_clk;
            if (req_n || rst_out) begin
                pend_rises <= '0;
            end else if (cpu_clk && !cpu_prev && pend_rises != 4'hF) begin
                pend_rises <= pend_rises + 4'd1;
            end
        end
    end

    // R4: generated clocks move only after a source tick
    a_r4_hold_without_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        !src_tick |=> ($stable(cpu_clk) && $stable(per_clk)));

    // R2: a high phase lasts a single tick
    a_r2_high_one_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        (cpu_clk && src_tick) |=> !cpu_clk);

    // R9: peripheral clock moves only with a processor clock rise
    a_r9_per_on_cpu_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(per_clk) |-> $rose(cpu_clk));

    // R6: reset output moves only as the processor clock falls
    a_r6_rst_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(rst_out) |-> $fell(cpu_clk));

    // R8: power-on values
    a_r8_por_state: assert property (@(posedge clk_i)
        rst_i |=> (!cpu_clk && !per_clk && rst_out));

    // R5: request reaches rst_out within four processor clock rises
    a_r5_assert_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        pend_rises < 4'd4);

endmodule

bind cpu_clkrst_gen cpu_clkrst_gen_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .src_tick(src_tick),
    .req_n   (req_n_i),
    .cpu_clk (cpu_clk_o),
    .per_clk (per_clk_o),
    .rst_out (rst_o)
);

// File: tb/cpu_clkrst_gen_bench.sv
module cpu_clkrst_gen_bench;

    logic clk = 1'b0;
    logic rst_i;
    logic fc_sel;
    logic osc_in;
    logic ext_in;
    logic req_n;
    logic osc_o;
    logic cpu_clk;
    logic per_clk;
    logic rst_o;

    int osc_half = 2;
    int ext_half = 3;
    bit osc_run  = 1'b1;
    bit ext_run  = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cpu_clkrst_gen u_cpu_clkrst_gen (
        .clk_i    (clk),
        .rst_i    (rst_i),
        .fc_sel_i (fc_sel),
        .osc_i    (osc_in),
        .ext_i    (ext_in),
        .req_n_i  (req_n),
        .osc_o    (osc_o),
        .cpu_clk_o(cpu_clk),
        .per_clk_o(per_clk),
        .rst_o    (rst_o)
    );

    // Source generators, driven away from the sampling edge.
    initial begin
        osc_in = 1'b0;
        forever begin
            repeat (osc_half) @(negedge clk);
            if (osc_run) osc_in = ~osc_in;
        end
    end

    initial begin
        ext_in = 1'b0;
        forever begin
            repeat (ext_half) @(negedge clk);
            if (ext_run) ext_in = ~ext_in;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic pick(input int which);
        return (which == 0) ? cpu_clk : per_clk;
    endfunction

    // Advance negedge samples until the signal shows the given level.
    task automatic wait_level(input int which, input logic lvl, output int n);
        n = 0;
        while (pick(which) !== lvl && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(input int which, output int hi, output int per);
        int n;
        int lo;
        wait_level(which, 1'b0, n);
        wait_level(which, 1'b1, n);
        wait_level(which, 1'b0, hi);
        wait_level(which, 1'b1, lo);
        per = hi + lo;
    endtask

    task automatic t_power_on();
        int n;
        rst_i  = 1'b1;
        fc_sel = 1'b0;
        req_n  = 1'b1;
        repeat (6) @(negedge clk);
        check(cpu_clk == 1'b0, "R8", "cpu_clk in reset", cpu_clk, 0);
        check(per_clk == 1'b0, "R8", "per_clk in reset", per_clk, 0);
        check(rst_o == 1'b1, "R8", "rst_o in reset", rst_o, 1);
        rst_i = 1'b0;
        wait_level(0, 1'b1, n);
        check(per_clk == 1'b1, "R8", "per_clk on first cpu_clk rise", per_clk, 1);
    endtask

    task automatic t_rates(input bit sel, input int half);
        int hi;
        int per;
        int src_p;
        string req;
        fc_sel = sel;
        src_p  = 2 * half;
        req    = sel ? "R1 ext" : "R1 osc";
        measure(0, hi, per);
        measure(0, hi, per);
        check(per == 3 * src_p, "R2", {req, " cpu_clk period"}, per, 3 * src_p);
        check(hi == src_p, "R2", {req, " cpu_clk high"}, hi, src_p);
        measure(1, hi, per);
        check(per == 6 * src_p, "R3", {req, " per_clk period"}, per, 6 * src_p);
        check(hi == 3 * src_p, "R3", {req, " per_clk high"}, hi, 3 * src_p);
    endtask

    task automatic t_echo(input bit sel);
        int bad;
        bad = 0;
        fc_sel = sel;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            #1;
            if (osc_o !== (sel ? ext_in : osc_in)) bad++;
        end
        check(bad == 0, "R1", sel ? "osc_o follows ext" : "osc_o follows osc", bad, 0);
    endtask

    task automatic t_freeze();
        logic c0;
        logic p0;
        int moved;
        moved = 0;
        fc_sel  = 1'b0;
        osc_run = 1'b0;
        repeat (10) @(negedge clk);
        c0 = cpu_clk;
        p0 = per_clk;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cpu_clk !== c0 || per_clk !== p0) moved++;
        end
        check(moved == 0, "R4", "clocks held with source stopped", moved, 0);
        osc_run = 1'b1;
    endtask

    task automatic t_req_assert();
        int rises;
        int guard;
        logic pc;
        logic pr;
        bit on_fall;
        rises   = 0;
        guard   = 0;
        on_fall = 1'b0;
        @(negedge clk);
        req_n = 1'b0;
        pc = cpu_clk;
        pr = rst_o;
        while (guard < 2000) begin
            @(negedge clk);
            guard++;
            if (cpu_clk && !pc) rises++;
            if (rst_o && !pr) begin
                on_fall = (pc == 1'b1 && cpu_clk == 1'b0);
                break;
            end
            pc = cpu_clk;
            pr = rst_o;
        end
        check(rst_o == 1'b1, "R5", "rst_o raised", rst_o, 1);
        check(rises < 4, "R5", "cpu_clk rises before rst_o", rises, 3);
        check(on_fall, "R6", "rst_o rise on cpu_clk fall", on_fall, 1);
    endtask

    task automatic t_req_release();
        int falls;
        int guard;
        logic pc;
        bit on_fall;
        falls   = 0;
        guard   = 0;
        on_fall = 1'b0;
        pc = cpu_clk;
        while (!(pc && !cpu_clk) && guard < 2000) begin
            pc = cpu_clk;
            @(negedge clk);
            guard++;
        end
        req_n = 1'b0;
        req_n = 1'b1;
        pc = cpu_clk;
        guard = 0;
        while (rst_o && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (pc && !cpu_clk) begin
                falls++;
                if (!rst_o) on_fall = 1'b1;
            end
            pc = cpu_clk;
        end
        check(rst_o == 1'b0, "R7", "rst_o released", rst_o, 0);
        check(falls == 1, "R7", "cpu_clk falls until release", falls, 1);
        check(on_fall, "R6", "rst_o drop on cpu_clk fall", on_fall, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_power_on();
        t_rates(1'b0, osc_half);
        t_echo(1'b0);
        t_echo(1'b1);
        t_rates(1'b1, ext_half);
        t_freeze();
        t_rates(1'b0, osc_half);
        t_req_assert();
        t_req_release();
        fc_sel = 1'b1;
        t_req_assert();
        t_req_release();
        finish_run();
    end

endmodule